// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets synchronous on-chip logic read and write an external byte-wide asynchronous static RAM with 2^19 locations. A requester raises `req` for one clock while `rdy` is high, with `req_wr` choosing a write (1) or a read (0), plus a 19-bit address and a byte of write data. The controller then sequences the memory strobes and finishes with a one-clock `done` pulse. For a read, the captured byte appears on `rdata` in that same cycle.

Every memory timing limit is a nanosecond parameter. Each one is turned into a whole number of clock cycles by rounding up against `CLK_NS`, with at least one cycle per phase. Writes are ended by the rising edge of write enable while chip enable is still low. Output enable stays high for the whole write. After each read, a bus turnaround gap keeps the memory's output drivers and the controller's data drivers from ever overlapping. No access may start until a power-up wait has elapsed after reset.

Top module: `asram_ctrl`

## Requirements
- R1: While `rst` is high, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are 1, `rdy` and `done` are 0, `rdata` is 0 and the controller does not drive `sram_dq`.
- R2: After `rst` falls, `rdy` stays 0 and `sram_ce_n` stays 1 for at least NPU = ceil(T_PWRUP_NS/CLK_NS) clock edges. `rdy` becomes 1 one edge after that. With the bench settings (40 ns at 4 ns) NPU is 10.
- R3: A request is taken only on a clock edge where `rdy` is 1. A request made while `rdy` is 0 causes no memory activity and changes no stored byte. A change to the request fields during an access does not alter that access.
- R4: A write holds `sram_ce_n` low for NWP+2 cycles and `sram_we_n` low for NWP cycles inside that window, with `sram_oe_n` at 1 throughout. NWP = max(ceil(T_PWE), ceil(T_SD), ceil(T_WC)-2), giving 3 and 5 cycles at the defaults.
- R5: During a write, address and data are driven from the first chip-enable-low cycle through the cycle after write enable rises. `sram_we_n` rises while `sram_ce_n` is still 0, with the data unchanged across that edge.
- R6: A read holds `sram_ce_n` and `sram_oe_n` low and `sram_we_n` high for NRD = max(ceil(T_AA), ceil(T_RC), ceil(T_DOE)) cycles, which is 3 at the defaults. The controller does not drive the bus, and the byte on `sram_dq` at the last edge of that window is returned on `rdata`.
- R7: Every accepted access produces exactly one `done` cycle. `rdata` keeps the last read byte until the next read completes.
- R8: After a read, all strobes are high and `rdy` is 0 for NTA = ceil(T_HZOE/CLK_NS) cycles, which is 2 at the defaults. A request is then accepted one cycle after `rdy` returns, so a write following a read always sees idle, released-bus cycles first.
- R9: `rdy` is 1 only while no access is in progress, and `sram_we_n` and `sram_oe_n` are never 0 together.
- R10: `sram_addr` does not change while `sram_ce_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, sampled when `rdy` is 1 |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Memory location |
| req_wdata | input | 8 | Byte to write |
| rdy | output | 1 | Controller idle and powered up |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | 8 | Last byte read |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_addr | output | 19 | Memory address lines |
| sram_dq | inout | 8 | Bidirectional data bus |

## Verification
The assertions assume that reset is applied at start-up and that the memory drives the bus only while chip enable and output enable are low with write enable high. They also assume the requester treats `rdy` as the sole permission to start.

The bench memory model follows that drive rule exactly and commits a byte on the rising edge of write enable. Its stimulus keeps `req` to one cycle per access. The exceptions are the deliberate cases, which hold or pulse `req` while `rdy` is 0 so the ignore rule can be observed at the pins.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPULSE,
    ST_WHOLD,
    ST_READ,
    ST_TURN
  } asram_st_e;

  // nanoseconds to whole clocks, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_pwrup.sv
module asram_pwrup #(
  parameter int NPU = 250000
) (
  input  logic clk,
  input  logic rst,
  output logic pwr_ok
);
  localparam int PW = $clog2(NPU + 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      pwr_ok <= 1'b0;
    end else if (!pwr_ok) begin
      if (cnt == PW'(NPU - 1)) pwr_ok <= 1'b1;
      else                     cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int NWP = 3,
  parameter int NRD = 3,
  parameter int NTA = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok,
  input  logic req,
  input  logic req_wr,
  output logic accept,
  output logic capture,
  output logic ce_n,
  output logic we_n,
  output logic oe_n,
  output logic drive,
  output logic done,
  output logic rdy
);
  localparam int CMAX = imax(imax(NWP, NRD), NTA);
  localparam int CW   = $clog2(CMAX + 1);

  asram_st_e     st;
  logic [CW-1:0] cnt;

  assign accept  = req && rdy;
  assign capture = (st == ST_READ) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      drive <= 1'b0;
      done  <= 1'b0;
      rdy   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            rdy  <= 1'b0;
            ce_n <= 1'b0;
            if (req_wr) begin
              drive <= 1'b1;
              st    <= ST_WSET;
            end else begin
              oe_n <= 1'b0;
              cnt  <= CW'(NRD - 1);
              st   <= ST_READ;
            end
          end else begin
            rdy <= pwr_ok;
          end
        end
        ST_WSET: begin
          we_n <= 1'b0;
          cnt  <= CW'(NWP - 1);
          st   <= ST_WPULSE;
        end
        ST_WPULSE: begin
          if (cnt == '0) begin
            we_n <= 1'b1;
            st   <= ST_WHOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WHOLD: begin
          ce_n  <= 1'b1;
          drive <= 1'b0;
          done  <= 1'b1;
          rdy   <= 1'b1;
          st    <= ST_IDLE;
        end
        ST_READ: begin
          if (cnt == '0) begin
            ce_n <= 1'b1;
            oe_n <= 1'b1;
            done <= 1'b1;
            cnt  <= CW'(NTA - 1);
            st   <= ST_TURN;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TURN: begin
          if (cnt == '0) begin
            rdy <= 1'b1;
            st  <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/asram_dp.sv
module asram_dp #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          capture,
  input  logic          drive,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [AW-1:0] sram_addr,
  inout  wire  [DW-1:0] sram_dq,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] wdat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr <= '0;
      wdat_q    <= '0;
      rdata     <= '0;
    end else begin
      if (accept) begin
        sram_addr <= req_addr;
        wdat_q    <= req_wdata;
      end
      if (capture) rdata <= sram_dq;
    end
  end

  assign sram_dq = drive ? wdat_q : {DW{1'bz}};
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW         = 19,
  parameter int DW         = 8,
  parameter int CLK_NS     = 4,
  parameter int T_PWRUP_NS = 1000000,
  parameter int T_RC_NS    = 12,
  parameter int T_AA_NS    = 12,
  parameter int T_DOE_NS   = 6,
  parameter int T_WC_NS    = 12,
  parameter int T_PWE_NS   = 10,
  parameter int T_SD_NS    = 7,
  parameter int T_HZOE_NS  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rdy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [AW-1:0] sram_addr,
  inout  wire  [DW-1:0] sram_dq
);
  localparam int NPU = ns2cyc(T_PWRUP_NS, CLK_NS);
  localparam int NWP = imax(imax(ns2cyc(T_PWE_NS, CLK_NS), ns2cyc(T_SD_NS, CLK_NS)),
                            ns2cyc(T_WC_NS, CLK_NS) - 2);
  localparam int NRD = imax(imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_RC_NS, CLK_NS)),
                            ns2cyc(T_DOE_NS, CLK_NS));
  localparam int NTA = ns2cyc(T_HZOE_NS, CLK_NS);

  logic pwr_ok;
  logic accept;
  logic capture;
  logic drive;

  asram_pwrup #(.NPU(NPU)) u_pwr (
    .clk    (clk),
    .rst    (rst),
    .pwr_ok (pwr_ok)
  );

  asram_seq #(.NWP(NWP), .NRD(NRD), .NTA(NTA)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .pwr_ok  (pwr_ok),
    .req     (req),
    .req_wr  (req_wr),
    .accept  (accept),
    .capture (capture),
    .ce_n    (sram_ce_n),
    .we_n    (sram_we_n),
    .oe_n    (sram_oe_n),
    .drive   (drive),
    .done    (done),
    .rdy     (rdy)
  );

  asram_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .capture   (capture),
    .drive     (drive),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .sram_addr (sram_addr),
    .sram_dq   (sram_dq),
    .rdata     (rdata)
  );
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rdy,
  input logic          done,
  input logic          sram_ce_n,
  input logic          sram_we_n,
  input logic          sram_oe_n,
  input logic [AW-1:0] sram_addr,
  input logic [DW-1:0] sram_dq
);
  logic seen_rdy;

  always_ff @(posedge clk) begin
    if (rst)      seen_rdy <= 1'b0;
    else if (rdy) seen_rdy <= 1'b1;
  end

  AST_NO_EARLY_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !seen_rdy |-> sram_ce_n); // R2
  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> !sram_ce_n); // R4
  AST_WE_ENDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (!sram_ce_n && $stable(sram_dq))); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_oe_n) |-> (!rdy && sram_ce_n)); // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    rdy |-> sram_ce_n); // R9
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!sram_we_n && !sram_oe_n)); // R9
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr)); // R10
endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rdy       (rdy),
  .done      (done),
  .sram_ce_n (sram_ce_n),
  .sram_we_n (sram_we_n),
  .sram_oe_n (sram_oe_n),
  .sram_addr (sram_addr),
  .sram_dq   (sram_dq)
);

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;
  localparam int PU_CYC    = 10; // R2: 40 ns at 4 ns
  localparam int WE_CYC    = 3;  // R4
  localparam int WR_CE_CYC = 5;  // R4
  localparam int RD_CYC    = 3;  // R6
  localparam int TA_CYC    = 2;  // R8
  localparam int NV        = 12;

  // {write, address, data}; for reads the data field is the expected byte
  localparam logic [27:0] VEC [0:NV-1] = '{
    {1'b1, 19'h00000, 8'hA5},
    {1'b1, 19'h7FFFF, 8'h3C},
    {1'b1, 19'h12345, 8'h81},
    {1'b0, 19'h00000, 8'hA5},
    {1'b0, 19'h7FFFF, 8'h3C},
    {1'b1, 19'h12345, 8'h7E},
    {1'b0, 19'h12345, 8'h7E},
    {1'b1, 19'h55555, 8'h00},
    {1'b1, 19'h2AAAA, 8'hFF},
    {1'b0, 19'h55555, 8'h00},
    {1'b0, 19'h2AAAA, 8'hFF},
    {1'b0, 19'h00000, 8'hA5}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rdy, done, sram_ce_n, sram_we_n, sram_oe_n;
  logic [7:0]  rdata;
  logic [18:0] sram_addr;
  wire  [7:0]  sram_dq;

  always #2 clk = ~clk;

  asram_ctrl #(.CLK_NS(4), .T_PWRUP_NS(40)) u0 (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rdy(rdy), .done(done), .rdata(rdata),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_addr(sram_addr), .sram_dq(sram_dq)
  );

  // memory model
  logic [7:0] mem [bit [18:0]];
  logic [7:0] m_out;
  always_comb m_out = mem.exists(sram_addr) ? mem[sram_addr] : 8'h00;
  assign sram_dq = (!sram_ce_n && !sram_oe_n && sram_we_n) ? m_out : 8'hzz;
  always @(posedge sram_we_n) if (!rst && !sram_ce_n) mem[sram_addr] = sram_dq;

  int n_chk = 0;
  int n_bad = 0;
  bit fin = 1'b0;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [18:0] a, input logic [7:0] d,
                        output int gap, output int ce_lo, output int we_lo,
                        output int oe_lo, output logic [7:0] rd);
    gap = 0; ce_lo = 0; we_lo = 0; oe_lo = 0;
    while (!rdy && gap < 40) begin
      gap++;
      @(negedge clk);
    end
    gap++;
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < 40 && !done; k++) begin
      if (!sram_ce_n) begin
        ce_lo++;
        chk(sram_addr == a, "R10", int'(sram_addr), int'(a));
        if (wr) chk(sram_dq == d, "R5", int'(sram_dq), int'(d));
      end
      if (!sram_we_n) we_lo++;
      if (!sram_oe_n) oe_lo++;
      if (!sram_we_n && !sram_oe_n) chk(1'b0, "R9", 0, 1);
      @(negedge clk);
    end
    chk(done == 1'b1, "R7", int'(done), 1);
    rd = rdata;
    @(negedge clk);
    chk(done == 1'b0, "R7", int'(done), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int gap, ce_lo, we_lo, oe_lo;
    logic [7:0] rd;
    logic [7:0] last_rd;
    bit prev_rd;
    mem[19'h00AAA] = 8'h5A;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(sram_ce_n && sram_we_n && sram_oe_n, "R1",
        int'({sram_ce_n, sram_we_n, sram_oe_n}), 7);
    chk(!rdy && !done, "R1", int'({rdy, done}), 0);
    chk(rdata == 8'h00, "R1", int'(rdata), 0);
    rst = 1'b0;

    // R2 / R3: power-up wait, requests ignored
    for (int e = 1; e <= PU_CYC; e++) begin
      @(negedge clk);
      chk(sram_ce_n == 1'b1, "R2", int'(sram_ce_n), 1);
      chk(rdy == 1'b0, "R2", int'(rdy), 0);
      if (e >= 2 && e < PU_CYC) begin
        req = 1'b1; req_wr = 1'b1; req_addr = 19'h00AAA; req_wdata = 8'hEE;
      end else begin
        req = 1'b0;
      end
    end
    @(negedge clk);
    chk(rdy == 1'b1, "R2", int'(rdy), 1);

    // vector table
    prev_rd = 1'b0;
    last_rd = 8'h00;
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][27], VEC[i][26:8], VEC[i][7:0], gap, ce_lo, we_lo, oe_lo, rd);
      if (VEC[i][27]) begin
        chk(we_lo == WE_CYC, "R4", we_lo, WE_CYC);
        chk(ce_lo == WR_CE_CYC, "R4", ce_lo, WR_CE_CYC);
        chk(oe_lo == 0, "R4", oe_lo, 0);
        chk(rd == last_rd, "R7", int'(rd), int'(last_rd));
      end else begin
        chk(ce_lo == RD_CYC, "R6", ce_lo, RD_CYC);
        chk(oe_lo == RD_CYC, "R6", oe_lo, RD_CYC);
        chk(we_lo == 0, "R6", we_lo, 0);
        chk(rd == VEC[i][7:0], "R6", int'(rd), int'(VEC[i][7:0]));
        last_rd = rd;
      end
      if (i > 0) chk(gap == (prev_rd ? TA_CYC : 1), "R8", gap, prev_rd ? TA_CYC : 1);
      prev_rd = !VEC[i][27];
    end

    // R3: request while rdy is low after a read
    chk(rdy == 1'b0, "R8", int'(rdy), 0);
    req = 1'b1; req_wr = 1'b1; req_addr = 19'h00AAA; req_wdata = 8'hEE;
    @(negedge clk);
    req = 1'b0;
    chk(sram_ce_n == 1'b1, "R3", int'(sram_ce_n), 1);
    access(1'b0, 19'h00AAA, 8'h00, gap, ce_lo, we_lo, oe_lo, rd);
    chk(rd == 8'h5A, "R3", int'(rd), 8'h5A);

    // R3: request fields change during a write
    while (!rdy) @(negedge clk);
    req = 1'b1; req_wr = 1'b1; req_addr = 19'h00CCC; req_wdata = 8'h77;
    @(negedge clk);
    req_addr = 19'h00DDD; req_wdata = 8'h99;
    for (int k = 0; k < 4; k++) begin
      chk(sram_addr == 19'h00CCC, "R3", int'(sram_addr), 19'h00CCC);
      chk(rdy == 1'b0, "R9", int'(rdy), 0);
      @(negedge clk);
    end
    req = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    access(1'b0, 19'h00DDD, 8'h00, gap, ce_lo, we_lo, oe_lo, rd);
    chk(rd == 8'h00, "R3", int'(rd), 0);
    access(1'b0, 19'h00CCC, 8'h00, gap, ce_lo, we_lo, oe_lo, rd);
    chk(rd == 8'h77, "R3", int'(rd), 8'h77);

    fin = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule